// File: doc/BRIEF.md
# I2C Master FIFO and Interrupt Unit

This block sits between a register bus and an I2C transfer engine. It holds two byte-wide 128-entry queues: one for bytes the host queues for transmission, one for bytes the engine has received. It also holds a queue configuration register with a high and a low threshold, a level readback, and a pair of interrupt enable and status registers. Software pushes transmit bytes and pops receive bytes through register accesses. The engine pops transmit bytes and pushes receive bytes through a direct side port.

The engine reports transfer events as single-cycle pulses. The block captures each of them, together with the queue-level events, in a sticky status register. Software clears status bits by writing ones to them. One interrupt line stays high while any enabled status bit is set. The receive-level event fires against a programmable high threshold. During a long read, software re-arms it with the remaining byte count after each drain.

Top module: `mfifo_irq_unit`

## Requirements
- R1: After reset both queue counts, the status register, the enable register and both thresholds read zero, and `irq` is low.
- R2: Bytes written at word address 0 reach `eng_tx_byte` in write order, one per `eng_tx_pop`. A push into a queue that holds 128 bytes is dropped, and the count stays at 128.
- R3: Bytes pushed by the engine come out in order on reads of word address 1, and each read removes one byte. A read of the empty receive queue returns the byte most recently removed and leaves the count unchanged.
- R4: Word address 3 returns the receive count in bits 7:0 and the transmit count in bits 23:16.
- R5: Word address 2 holds the low threshold in bits 7:0 and the high threshold in bits 15:8. Writing a one to bit 16 empties both queues in that cycle, and bit 16 reads back as zero.
- R6: Status and enable share these bit positions: 25 address not acknowledged, 13 address acknowledged, 12 data done, 11 arbitration lost, 4 queue full, 3 transmit queue emptied, 2 receive at or above high threshold, 0 bus error. Each engine pulse sets its bit on the next clock edge. All other bits read zero.
- R7: A write to word address 5 clears exactly the status bits written as one and leaves the others alone. If a set and a clear hit the same bit in one cycle, the bit ends up set.
- R8: `irq` is high exactly when some status bit is set together with its enable bit (word address 4). Writing zero to the enable register drops `irq` and leaves the status unchanged.
- R9: Bit 2 sets when the receive count goes from below the nonzero high threshold to at or above it. Thresholds up to 128 are valid. The bit does not set again until the condition has gone away and come back, for example after a drain or a new threshold.
- R10: Bit 3 sets when an engine pop removes the last queued transmit byte. Emptying the queue through the bit-16 flush does not set it.
- R11: Bit 4 sets when either queue reaches 128 bytes. It does not set again while the queue stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at address 1) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for the addressed word, valid in the strobe cycle |
| eng_tx_pop | input | 1 | Engine takes the transmit head byte |
| eng_tx_byte | output | 8 | Transmit head byte, or the last byte removed when empty |
| eng_tx_ready | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_ev_addr_nack | input | 1 | Pulse: address not acknowledged |
| eng_ev_addr_ack | input | 1 | Pulse: address acknowledged |
| eng_ev_done | input | 1 | Pulse: data transfer complete |
| eng_ev_arb_lost | input | 1 | Pulse: arbitration lost |
| eng_ev_bus_err | input | 1 | Pulse: bus error |
| irq | output | 1 | Interrupt request |

## Verification
Transmit ordering is tested with short bursts and with an overfilled queue. These show apart correct pointer wrap, dropped pushes and the difference between draining and flushing. The receive threshold is tested just below, at and above its value, then cleared while still above it, then re-armed at a lower value and at 128. These separate level capture from edge capture. Engine pulses are applied one at a time, and then colliding with clears in the same cycle, to expose bit-position and priority faults. A long seeded random mix of pushes, pops, threshold changes, flushes, clears and enable writes is compared against a bench model to catch interaction faults the directed cases miss.

// File: rtl/mfifo_irq_pkg.sv
package mfifo_irq_pkg;

  // Register word addresses.
  typedef enum logic [2:0] {
    ADDR_TXPUSH = 3'd0,
    ADDR_RXPOP  = 3'd1,
    ADDR_FCFG   = 3'd2,
    ADDR_LEVEL  = 3'd3,
    ADDR_IEN    = 3'd4,
    ADDR_ISTAT  = 3'd5
  } reg_addr_e;

  // Status / enable bit positions (decoded by software, so fixed).
  localparam int unsigned BIT_NACK  = 25;
  localparam int unsigned BIT_AACK  = 13;
  localparam int unsigned BIT_DONE  = 12;
  localparam int unsigned BIT_ARB   = 11;
  localparam int unsigned BIT_FULL  = 4;
  localparam int unsigned BIT_EMPTY = 3;
  localparam int unsigned BIT_HIGH  = 2;
  localparam int unsigned BIT_BERR  = 0;

  localparam logic [31:0] IRQ_MASK = (32'd1 << BIT_NACK) | (32'd1 << BIT_AACK) |
                                     (32'd1 << BIT_DONE) | (32'd1 << BIT_ARB)  |
                                     (32'd1 << BIT_FULL) | (32'd1 << BIT_EMPTY) |
                                     (32'd1 << BIT_HIGH) | (32'd1 << BIT_BERR);
  localparam logic [31:0] ENG_MASK = (32'd1 << BIT_NACK) | (32'd1 << BIT_AACK) |
                                     (32'd1 << BIT_DONE) | (32'd1 << BIT_ARB)  |
                                     (32'd1 << BIT_BERR);

  // Queue configuration fields.
  localparam int unsigned THR_W     = 8;
  localparam int unsigned LO_LSB    = 0;
  localparam int unsigned HI_LSB    = 8;
  localparam int unsigned FLUSH_BIT = 16;

  // Level readback fields.
  localparam int unsigned RXLVL_LSB = 0;
  localparam int unsigned TXLVL_LSB = 16;

endpackage

// File: rtl/mfifo_rst_sync.sv
module mfifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/mfifo_buf.sv
module mfifo_buf #(
  parameter  int unsigned DEPTH  = 128,
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cnt_d,
  output logic              drained
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [AW-1:0]    PTR_LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [DATA_W-1:0] last_q, last_d;
  logic              push_ok, pop_ok;

  // Next state
  always_comb begin
    push_ok = push && (cnt_q != CNT_FULL);
    pop_ok  = pop  && (cnt_q != '0);
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    last_d  = last_q;
    drained = 1'b0;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok) begin
        rd_d   = (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
        last_d = mem[rd_q];
      end
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
      drained = pop_ok && !push_ok && (cnt_q == CNT_W'(1));
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  // Storage, no reset
  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_q] <= push_data;
  end

  assign rd_data = (cnt_q == '0) ? last_q : mem[rd_q];

endmodule

// File: rtl/mfifo_irq_ctrl.sv
module mfifo_irq_ctrl
  import mfifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_nack,
  input  logic             ev_aack,
  input  logic             ev_done,
  input  logic             ev_arb,
  input  logic             ev_berr,
  input  logic             tx_drained,
  input  logic [CNT_W-1:0] rx_cnt_d,
  input  logic [CNT_W-1:0] tx_cnt_d,
  input  logic [THR_W-1:0] hi_thr_d,
  input  logic             en_wr,
  input  logic             stat_wr,
  input  logic [31:0]      wdata,
  output logic [31:0]      stat_q,
  output logic [31:0]      en_q,
  output logic             irq
);

  logic        hi_cond_d, hi_cond_q;
  logic        full_cond_d, full_cond_q;
  logic [31:0] set_vec, clr_vec, stat_d, en_d;

  // Next state
  always_comb begin
    hi_cond_d   = (hi_thr_d != '0) && (32'(rx_cnt_d) >= 32'(hi_thr_d));
    full_cond_d = (32'(rx_cnt_d) == DEPTH) || (32'(tx_cnt_d) == DEPTH);

    set_vec = '0;
    set_vec[BIT_NACK]  = ev_nack;
    set_vec[BIT_AACK]  = ev_aack;
    set_vec[BIT_DONE]  = ev_done;
    set_vec[BIT_ARB]   = ev_arb;
    set_vec[BIT_BERR]  = ev_berr;
    set_vec[BIT_EMPTY] = tx_drained;
    set_vec[BIT_HIGH]  = hi_cond_d && !hi_cond_q;
    set_vec[BIT_FULL]  = full_cond_d && !full_cond_q;

    clr_vec = stat_wr ? (wdata & IRQ_MASK) : '0;
    stat_d  = (stat_q & ~clr_vec) | set_vec;
    en_d    = en_wr ? (wdata & IRQ_MASK) : en_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q      <= '0;
      en_q        <= '0;
      hi_cond_q   <= 1'b0;
      full_cond_q <= 1'b0;
    end else begin
      stat_q      <= stat_d;
      en_q        <= en_d;
      hi_cond_q   <= hi_cond_d;
      full_cond_q <= full_cond_d;
    end
  end

  assign irq = |(stat_q & en_q);

endmodule

// File: rtl/mfifo_irq_unit.sv
module mfifo_irq_unit
  import mfifo_irq_pkg::*;
#(
  parameter  int unsigned DEPTH  = 128,
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              eng_tx_pop,
  output logic [DATA_W-1:0] eng_tx_byte,
  output logic              eng_tx_ready,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_byte,
  input  logic              eng_ev_addr_nack,
  input  logic              eng_ev_addr_ack,
  input  logic              eng_ev_done,
  input  logic              eng_ev_arb_lost,
  input  logic              eng_ev_bus_err,
  output logic              irq
);

  logic              rst_sync_n;
  logic              wr_tx, rd_rx, wr_cfg, wr_en, wr_stat, flush;
  logic [THR_W-1:0]  hi_q, hi_d, lo_q, lo_d;
  logic [DATA_W-1:0] rx_head;
  logic [CNT_W-1:0]  tx_cnt, tx_cnt_d, rx_cnt, rx_cnt_d;
  logic              tx_drained, rx_drained;
  logic [31:0]       stat_q, en_q;

  mfifo_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Register decode
  always_comb begin
    wr_tx   = bus_wr && (bus_addr == ADDR_TXPUSH);
    rd_rx   = bus_rd && (bus_addr == ADDR_RXPOP);
    wr_cfg  = bus_wr && (bus_addr == ADDR_FCFG);
    wr_en   = bus_wr && (bus_addr == ADDR_IEN);
    wr_stat = bus_wr && (bus_addr == ADDR_ISTAT);
    flush   = wr_cfg && bus_wdata[FLUSH_BIT];
    hi_d    = wr_cfg ? bus_wdata[HI_LSB +: THR_W] : hi_q;
    lo_d    = wr_cfg ? bus_wdata[LO_LSB +: THR_W] : lo_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  mfifo_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx_buf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush     (flush),
    .push      (wr_tx),
    .push_data (bus_wdata[DATA_W-1:0]),
    .pop       (eng_tx_pop),
    .rd_data   (eng_tx_byte),
    .cnt_q     (tx_cnt),
    .cnt_d     (tx_cnt_d),
    .drained   (tx_drained)
  );

  mfifo_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx_buf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush     (flush),
    .push      (eng_rx_push),
    .push_data (eng_rx_byte),
    .pop       (rd_rx),
    .rd_data   (rx_head),
    .cnt_q     (rx_cnt),
    .cnt_d     (rx_cnt_d),
    .drained   (rx_drained)
  );

  mfifo_irq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_irq_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ev_nack    (eng_ev_addr_nack),
    .ev_aack    (eng_ev_addr_ack),
    .ev_done    (eng_ev_done),
    .ev_arb     (eng_ev_arb_lost),
    .ev_berr    (eng_ev_bus_err),
    .tx_drained (tx_drained),
    .rx_cnt_d   (rx_cnt_d),
    .tx_cnt_d   (tx_cnt_d),
    .hi_thr_d   (hi_d),
    .en_wr      (wr_en),
    .stat_wr    (wr_stat),
    .wdata      (bus_wdata),
    .stat_q     (stat_q),
    .en_q       (en_q),
    .irq        (irq)
  );

  assign eng_tx_ready = (tx_cnt != '0);

  // Read mux; rx_drained has no consumer on the receive side
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_RXPOP: bus_rdata = 32'(rx_head) | {31'd0, 1'b0 & rx_drained};
      ADDR_FCFG:  bus_rdata = (32'(hi_q) << HI_LSB) | (32'(lo_q) << LO_LSB);
      ADDR_LEVEL: bus_rdata = (32'(rx_cnt) << RXLVL_LSB) | (32'(tx_cnt) << TXLVL_LSB);
      ADDR_IEN:   bus_rdata = en_q;
      ADDR_ISTAT: bus_rdata = stat_q;
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mfifo_irq_unit_chk.sv
module mfifo_irq_unit_chk
  import mfifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [2:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             eng_tx_pop,
  input logic             eng_rx_push,
  input logic             eng_ev_addr_nack,
  input logic             eng_ev_addr_ack,
  input logic             eng_ev_done,
  input logic             eng_ev_arb_lost,
  input logic             eng_ev_bus_err,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [31:0]      stat_q,
  input logic             irq
);

  logic any_ev;
  assign any_ev = eng_ev_addr_nack | eng_ev_addr_ack | eng_ev_done |
                  eng_ev_arb_lost | eng_ev_bus_err;

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_cnt) <= DEPTH) && (32'(rx_cnt) <= DEPTH));

  assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_cnt) == DEPTH) && bus_wr && (bus_addr == ADDR_TXPUSH) && !eng_tx_pop
    |=> (32'(tx_cnt) == DEPTH));

  assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0) && bus_rd && (bus_addr == ADDR_RXPOP) && !eng_rx_push
    |=> (rx_cnt == '0));

  assert_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (bus_addr == ADDR_FCFG) && bus_wdata[FLUSH_BIT]
    |=> (tx_cnt == '0) && (rx_cnt == '0));

  assert_unused_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~IRQ_MASK) == '0);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_ev_done |=> stat_q[BIT_DONE]);

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (bus_addr == ADDR_ISTAT) && !any_ev
    |=> ((stat_q & $past(bus_wdata) & ENG_MASK) == '0));

  assert_silence_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (bus_addr == ADDR_IEN) && (bus_wdata == '0) |=> !irq);

endmodule

bind mfifo_irq_unit mfifo_irq_unit_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_sync_n),
  .bus_wr           (bus_wr),
  .bus_rd           (bus_rd),
  .bus_addr         (bus_addr),
  .bus_wdata        (bus_wdata),
  .eng_tx_pop       (eng_tx_pop),
  .eng_rx_push      (eng_rx_push),
  .eng_ev_addr_nack (eng_ev_addr_nack),
  .eng_ev_addr_ack  (eng_ev_addr_ack),
  .eng_ev_done      (eng_ev_done),
  .eng_ev_arb_lost  (eng_ev_arb_lost),
  .eng_ev_bus_err   (eng_ev_bus_err),
  .tx_cnt           (tx_cnt),
  .rx_cnt           (rx_cnt),
  .stat_q           (stat_q),
  .irq              (irq)
);

// File: tb/mfifo_irq_unit_tb_top.sv
module mfifo_irq_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 128;
  localparam logic [31:0] MASK = 32'h0200_381D;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        eng_tx_pop, eng_tx_ready;
  logic [7:0]  eng_tx_byte;
  logic        eng_rx_push;
  logic [7:0]  eng_rx_byte;
  logic [4:0]  ev;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  mfifo_irq_unit dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_wr           (bus_wr),
    .bus_rd           (bus_rd),
    .bus_addr         (bus_addr),
    .bus_wdata        (bus_wdata),
    .bus_rdata        (bus_rdata),
    .eng_tx_pop       (eng_tx_pop),
    .eng_tx_byte      (eng_tx_byte),
    .eng_tx_ready     (eng_tx_ready),
    .eng_rx_push      (eng_rx_push),
    .eng_rx_byte      (eng_rx_byte),
    .eng_ev_addr_nack (ev[4]),
    .eng_ev_addr_ack  (ev[3]),
    .eng_ev_done      (ev[2]),
    .eng_ev_arb_lost  (ev[1]),
    .eng_ev_bus_err   (ev[0]),
    .irq              (irq)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Bench model of the requirements
  logic [7:0]  q_tx[$];
  logic [7:0]  q_rx[$];
  logic [7:0]  last_tx, last_rx, m_hi, m_lo;
  logic [31:0] m_stat, m_en;
  bit          p_hc, p_fc;
  logic [31:0] got_rd, exp_rd;
  logic [7:0]  got_tx, exp_tx;

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd1:    return (q_rx.size() != 0) ? 32'(q_rx[0]) : 32'(last_rx);
      3'd2:    return {16'd0, m_hi, m_lo};
      3'd3:    return {8'd0, 8'(q_tx.size()), 8'd0, 8'(q_rx.size())};
      3'd4:    return m_en;
      3'd5:    return m_stat;
      default: return 32'd0;
    endcase
  endfunction

  task automatic step(input bit wr, input bit rd, input logic [2:0] a, input logic [31:0] wd,
                      input bit txpop, input bit rxpush, input logic [7:0] rxd, input logic [4:0] e);
    bit flush, txpu, txpo, rxpu, rxpo, drained, hc, fc;
    logic [31:0] sets;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    eng_tx_pop = txpop; eng_rx_push = rxpush; eng_rx_byte = rxd; ev = e;
    #1;
    got_rd = bus_rdata; exp_rd = exp_read(a);
    got_tx = eng_tx_byte; exp_tx = (q_tx.size() != 0) ? q_tx[0] : last_tx;
    flush   = wr && (a == 3'd2) && wd[16];
    txpu    = wr && (a == 3'd0) && (q_tx.size() < DEPTH);
    txpo    = txpop && (q_tx.size() > 0);
    rxpu    = rxpush && (q_rx.size() < DEPTH);
    rxpo    = rd && (a == 3'd1) && (q_rx.size() > 0);
    drained = 0;
    if (flush) begin
      q_tx.delete(); q_rx.delete();
    end else begin
      drained = txpo && !txpu && (q_tx.size() == 1);
      if (txpo) last_tx = q_tx.pop_front();
      if (txpu) q_tx.push_back(wd[7:0]);
      if (rxpo) last_rx = q_rx.pop_front();
      if (rxpu) q_rx.push_back(rxd);
    end
    if (wr && a == 3'd2) begin m_hi = wd[15:8]; m_lo = wd[7:0]; end
    sets = 0;
    hc = (m_hi != 0) && (q_rx.size() >= int'(m_hi));
    fc = (q_rx.size() == DEPTH) || (q_tx.size() == DEPTH);
    if (hc && !p_hc) sets[2] = 1;
    if (fc && !p_fc) sets[4] = 1;
    p_hc = hc; p_fc = fc;
    if (drained) sets[3] = 1;
    if (e[4]) sets[25] = 1;
    if (e[3]) sets[13] = 1;
    if (e[2]) sets[12] = 1;
    if (e[1]) sets[11] = 1;
    if (e[0]) sets[0]  = 1;
    if (wr && a == 3'd5) m_stat = m_stat & ~(wd & MASK);
    m_stat = m_stat | sets;
    if (wr && a == 3'd4) m_en = wd & MASK;
    @(posedge clk);
    #1;
    bus_wr = 0; bus_rd = 0; eng_tx_pop = 0; eng_rx_push = 0; ev = 0;
    chk(irq == |(m_stat & m_en), "R8 irq follows status and enable", 32'(irq), 32'(|(m_stat & m_en)));
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(1, 0, a, d, 0, 0, 8'd0, 5'd0);
  endtask

  task automatic rd_lit(input logic [2:0] a, input logic [31:0] lit, input string tag);
    step(0, 1, a, 32'd0, 0, 0, 8'd0, 5'd0);
    chk(got_rd == lit, tag, got_rd, lit);
    chk(got_rd == exp_rd, {tag, " (model)"}, got_rd, exp_rd);
  endtask

  task automatic rxpush(input logic [7:0] d);
    step(0, 0, 3'd0, 32'd0, 0, 1, d, 5'd0);
  endtask

  task automatic pulse(input logic [4:0] e);
    step(0, 0, 3'd0, 32'd0, 0, 0, 8'd0, e);
  endtask

  initial begin
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    eng_tx_pop = 0; eng_rx_push = 0; eng_rx_byte = 0; ev = 0;
    last_tx = 0; last_rx = 0; m_hi = 0; m_lo = 0; m_stat = 0; m_en = 0; p_hc = 0; p_fc = 0;
    void'($urandom(32'd7321));
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state, R4 level layout
    chk(irq == 1'b0, "R1 irq low after reset", 32'(irq), 32'd0);
    rd_lit(3'd3, 32'd0, "R1 R4 level after reset");
    rd_lit(3'd4, 32'd0, "R1 enable after reset");
    rd_lit(3'd5, 32'd0, "R1 status after reset");
    rd_lit(3'd2, 32'd0, "R1 thresholds after reset");

    // R2 transmit ordering, R10 empty event
    for (int i = 0; i < 5; i++) wr(3'd0, 32'(8'hA0 + i));
    rd_lit(3'd3, 32'd5 << 16, "R4 tx count field");
    chk(eng_tx_ready == 1'b1, "R2 tx ready", 32'(eng_tx_ready), 32'd1);
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 3'd0, 32'd0, 1, 0, 8'd0, 5'd0);
      chk(got_tx == 8'(8'hA0 + i), "R2 tx order", 32'(got_tx), 32'(8'hA0 + i));
    end
    rd_lit(3'd5, 32'h8, "R10 empty after last engine pop");
    wr(3'd5, 32'h8);
    rd_lit(3'd5, 32'h0, "R7 clear by writing one");

    // R2 overfill, R11 full on tx, R10 flush gives no empty event
    for (int i = 0; i < 130; i++) wr(3'd0, 32'(i));
    rd_lit(3'd3, 32'd128 << 16, "R2 push into full queue dropped");
    rd_lit(3'd5, 32'h10, "R11 full when tx reaches 128");
    step(0, 0, 3'd0, 32'd0, 1, 0, 8'd0, 5'd0);
    chk(got_tx == 8'd0, "R2 first byte after overfill", 32'(got_tx), 32'd0);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0001_0000);
    rd_lit(3'd3, 32'd0, "R5 flush empties queues");
    rd_lit(3'd5, 32'd0, "R10 flush sets no empty event");

    // R9 high threshold, R8 irq, R3 receive order
    wr(3'd2, 32'h0000_0402);
    rd_lit(3'd2, 32'h0000_0402, "R5 threshold fields");
    rxpush(8'h11); rxpush(8'h22); rxpush(8'h33);
    rd_lit(3'd5, 32'd0, "R9 below threshold");
    rxpush(8'h44);
    rd_lit(3'd5, 32'h4, "R9 at threshold");
    wr(3'd4, 32'h4);
    chk(irq == 1'b1, "R8 enabled bit raises irq", 32'(irq), 32'd1);
    wr(3'd5, 32'h4);
    chk(irq == 1'b0, "R8 cleared bit drops irq", 32'(irq), 32'd0);
    rxpush(8'h55);
    rd_lit(3'd5, 32'd0, "R9 no re-set while above");
    rd_lit(3'd1, 32'h11, "R3 rx order");
    rd_lit(3'd1, 32'h22, "R3 rx order");
    rd_lit(3'd1, 32'h33, "R3 rx order");
    rd_lit(3'd1, 32'h44, "R3 rx order");
    rd_lit(3'd1, 32'h55, "R3 rx order");
    rd_lit(3'd1, 32'h55, "R3 empty pop returns last byte");
    rd_lit(3'd3, 32'd0, "R3 empty pop keeps count");
    wr(3'd2, 32'h0000_0200);
    rxpush(8'h01);
    rd_lit(3'd5, 32'd0, "R9 re-armed below");
    rxpush(8'h02);
    rd_lit(3'd5, 32'h4, "R9 re-armed fires");
    wr(3'd4, 32'd0);
    wr(3'd5, 32'hFFFF_FFFF);

    // R9 threshold 128, R11 full on rx
    wr(3'd2, 32'h0001_8000);
    rd_lit(3'd2, 32'h0000_8000, "R5 flush bit reads zero");
    for (int i = 0; i < 127; i++) rxpush(8'(i));
    rd_lit(3'd5, 32'd0, "R9 127 below 128");
    rxpush(8'd127);
    rd_lit(3'd5, 32'h14, "R9 R11 at 128");
    rxpush(8'hEE);
    rd_lit(3'd3, 32'd128, "R11 rx push when full dropped");
    rd_lit(3'd1, 32'd0, "R3 first rx byte");
    wr(3'd2, 32'h0001_0000);
    wr(3'd5, 32'hFFFF_FFFF);

    // R6 positions, R7 priority and zero writes
    pulse(5'b10000); rd_lit(3'd5, 32'h0200_0000, "R6 address nack bit 25");
    pulse(5'b01000); rd_lit(3'd5, 32'h0200_2000, "R6 address ack bit 13");
    pulse(5'b00100); rd_lit(3'd5, 32'h0200_3000, "R6 done bit 12");
    pulse(5'b00010); rd_lit(3'd5, 32'h0200_3800, "R6 arbitration bit 11");
    pulse(5'b00001); rd_lit(3'd5, 32'h0200_3801, "R6 bus error bit 0");
    step(1, 0, 3'd5, 32'h0000_1000, 0, 0, 8'd0, 5'b00100);
    rd_lit(3'd5, 32'h0200_3801, "R7 set wins over clear");
    wr(3'd5, 32'd0);
    rd_lit(3'd5, 32'h0200_3801, "R7 zeros keep bits");
    wr(3'd5, 32'h0200_0001);
    rd_lit(3'd5, 32'h0000_3800, "R7 clears only ones");
    wr(3'd4, 32'hFFFF_FFFF);
    chk(irq == 1'b1, "R8 irq with enables", 32'(irq), 32'd1);
    rd_lit(3'd4, MASK, "R6 enable keeps defined bits");
    wr(3'd4, 32'd0);
    chk(irq == 1'b0, "R8 zero enable silences", 32'(irq), 32'd0);
    rd_lit(3'd5, 32'h0000_3800, "R8 status kept when silenced");

    // Random mix against the model
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom_range(0, 11);
      case (op)
        0, 1: wr(3'd0, 32'($urandom_range(0, 255)));
        2: begin
          step(0, 0, 3'd0, 32'd0, 1, 0, 8'd0, 5'd0);
          chk(got_tx == exp_tx, "R2 random tx byte", 32'(got_tx), 32'(exp_tx));
        end
        3, 4: rxpush(8'($urandom_range(0, 255)));
        5, 6: begin
          step(0, 1, 3'd1, 32'd0, 0, 0, 8'd0, 5'd0);
          chk(got_rd == exp_rd, "R3 random rx byte", got_rd, exp_rd);
        end
        7: wr(3'd2, {15'd0, 1'($urandom_range(0, 19) == 0), 8'($urandom_range(0, 9)), 8'($urandom_range(0, 255))});
        8: pulse(($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31)) : 5'd0);
        9: wr(3'd5, $urandom());
        10: wr(3'd4, $urandom());
        default: begin
          logic [2:0] a;
          a = 3'($urandom_range(2, 7));
          step(0, 1, a, 32'd0, 0, 0, 8'd0, 5'd0);
          chk(got_rd == exp_rd, "R4 R5 R6 random register read", got_rd, exp_rd);
        end
      endcase
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired got=%h exp=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule